// File: doc/BRIEF.md
# Calendar Timekeeper With Commit-Busy Flags

This block holds the wall-clock time of day and the calendar date and steps them forward once per second, on a single-cycle pulse that arrives from the low-speed clock logic. The host sees three words: a control word that carries two busy flags, a time word (hours, minutes, seconds) and a date word (day, month, year offset, leap flag). All fields are plain binary.

A host write to the time or date word is not applied at once. The value is held in a capture register, and the matching busy flag rises. The captured value then replaces the running word on the next seconds pulse, and the flag drops on that same pulse. Software polls the flags before it writes. Readers that need a consistent pair read both words twice and retry if they differ, because the words can step between two reads. The year is a 6-bit offset from 1970, covering 1970 to 2033. The leap flag is stored next to it and is recomputed whenever the year advances.

Top module: `cal_timekeeper`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0, the time word reads 0 (00:00:00) and the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0).
- R2: The time word is read at address 0x14, with seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. All other bits read 0.
- R3: The date word is read at address 0x10, with day in bits 4:0, month (1 to 12) in bits 11:8, year offset from 1970 in bits 21:16 and the leap flag in bit 22. The control word at address 0x00 shows the time-busy flag in bit 8 and the date-busy flag in bit 7. Any other address reads 0.
- R4: A write to the time word or the date word while that word's busy flag is clear captures the written value and sets that flag. The flag is visible one cycle after the write. The readable word keeps its old value until the commit.
- R5: On the first seconds pulse while a busy flag is set, the captured value becomes the readable word and the flag clears. A time commit replaces that second's increment.
- R6: A write to a word whose busy flag is set is ignored. The value captured first is the one committed.
- R7: On each seconds pulse with no time commit, the time advances by one second. Seconds wrap from 59 to 0, minutes from 59 to 0 and hours from 23 to 0. Between pulses the time holds.
- R8: Only the step from 23:59:59 to 00:00:00 advances the date. Day wraps to 1 after day 30 in months 4, 6, 9 and 11, after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 28 in month 2 when the leap flag is clear.
- R9: In month 2 with the leap flag set, day 28 steps to 29, and day 29 wraps to March 1.
- R10: When December 31 wraps, the month becomes 1 and the year offset increments, wrapping from 63 to 0. The leap flag becomes 1 exactly when 1970 plus the new offset is divisible by 4.
- R11: A date commit replaces the date on its pulse and discards any day carry from that pulse. The time still advances on that pulse unless a time commit is also pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |

## Verification
A busy flag rises in the cycle after the clock edge that accepts the write. A committed word, or a stepped one, changes right after the edge on which sec_tick is high, and the busy flag clears at that same edge. The bench drives every input at the falling edge and samples rd_data at the next falling edge, 1 ns after changing rd_addr. Each read therefore reflects exactly one more register update. Most scenarios first commit a chosen time and date with one pulse, check that the commit landed unchanged, then give one more pulse and check the stepped values.

// File: rtl/cal_pkg.sv
// Shared field layout, limits and record types for the calendar timekeeper.
// Assumes plain binary fields and a year kept as an offset from YEAR_BASE.
package cal_pkg;
    localparam int WORD_W = 32;

    localparam int SEC_W = 6;
    localparam int MIN_W = 6;
    localparam int HR_W  = 5;
    localparam int DAY_W = 5;
    localparam int MON_W = 4;
    localparam int YR_W  = 6;

    // Field positions are decoded by software, so they are fixed.
    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HR_LSB   = 16;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YR_LSB   = 16;
    localparam int LEAP_POS = 22;

    localparam int BUSY_TOD_POS  = 8;
    localparam int BUSY_DATE_POS = 7;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_DATE = 'h10;
    localparam int OFS_TIME = 'h14;

    localparam int SEC_LIMIT = 60;
    localparam int MIN_LIMIT = 60;
    localparam int HR_LIMIT  = 24;
    localparam int MON_LIMIT = 12;

    localparam int YEAR_BASE = 1970;
    // Offset residue (mod 4) at which the absolute year is divisible by 4.
    localparam logic [1:0] LEAP_PHASE = 2'((4 - (YEAR_BASE % 4)) % 4);

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } tod_t;

    typedef struct packed {
        logic             leap;
        logic [YR_W-1:0]  yr;
        logic [MON_W-1:0] mon;
        logic [DAY_W-1:0] day;
    } date_t;

    // Number of days in a month; February depends on the stored leap flag.
    function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] mon,
                                                   input logic leap);
        logic [DAY_W-1:0] n;
        case (mon)
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): n = DAY_W'(30);
            MON_W'(2):                                    n = leap ? DAY_W'(29) : DAY_W'(28);
            default:                                      n = DAY_W'(31);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/cal_commit_slot.sv
// Capture register with a busy flag for one host-writable word.
// Accepts a write only while idle, then hands the value over on the next
// seconds pulse. Assumes the tick is a single-cycle pulse.
module cal_commit_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_val,
    input  logic         tick,
    output logic         busy_q,
    output logic         commit,
    output logic [W-1:0] pend_q
);
    // Capture while idle, release on the tick that commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= '0;
        end else if (wr_hit && !busy_q) begin
            busy_q <= 1'b1;
            pend_q <= wr_val;
        end else if (tick && busy_q) begin
            busy_q <= 1'b0;
        end
    end

    // The commit strobe handed to the counter.
    always_comb commit = tick & busy_q;

    // R4: the flag rises only because a write was accepted.
    a_r4_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(wr_hit));

    // R5: the flag falls only on a seconds pulse.
    a_r5_busy_clears_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(tick));

    // R6: a write while busy leaves the captured value alone.
    a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(pend_q));
endmodule

// File: rtl/cal_tod_counter.sv
// Hours/minutes/seconds counter that steps on each seconds pulse, or loads a
// committed value on that pulse instead. Emits a one-cycle day carry when
// 23:59:59 wraps. Out-of-range loaded fields wrap at the next step.
module cal_tod_counter
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  tod_t load_val,
    output tod_t tod_q,
    output logic day_carry
);
    logic sec_end, min_end, hr_end;
    tod_t tod_next;

    // Successor time with cascaded wraps.
    always_comb begin
        sec_end  = tod_q.sec >= SEC_W'(SEC_LIMIT - 1);
        min_end  = tod_q.min >= MIN_W'(MIN_LIMIT - 1);
        hr_end   = tod_q.hr  >= HR_W'(HR_LIMIT - 1);
        tod_next = tod_q;
        tod_next.sec = sec_end ? '0 : tod_q.sec + SEC_W'(1);
        if (sec_end) begin
            tod_next.min = min_end ? '0 : tod_q.min + MIN_W'(1);
        end
        if (sec_end && min_end) begin
            tod_next.hr = hr_end ? '0 : tod_q.hr + HR_W'(1);
        end
    end

    // Time register: load wins over the increment on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_q <= '0;
        end else if (tick) begin
            tod_q <= load ? load_val : tod_next;
        end
    end

    // Day carry only on a real increment past the last second of the day.
    always_comb day_carry = tick & ~load & sec_end & min_end & hr_end;

    // R7: without a pulse the time holds.
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tod_q));

    // R5: a committed time appears unchanged after its pulse.
    a_r5_time_commit_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load) |=> (tod_q == $past(load_val)));

    // R7: after a plain step, the time is midnight exactly when a day carry fired.
    a_r7_midnight_after_carry: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry |=> (tod_q == '0));
endmodule

// File: rtl/cal_date_counter.sv
// Day/month/year counter with a stored leap flag. Advances one day per carry
// and loads a committed date instead when one is pending. Recomputes the leap
// flag from the year offset whenever the year steps.
module cal_date_counter
    import cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    input  logic  load,
    input  date_t load_val,
    output date_t date_q
);
    logic             last_day;
    logic             last_mon;
    logic [YR_W-1:0]  yr_inc;
    date_t            date_next;
    date_t            date_rst;

    // Reset date: first day of the base year, leap derived from offset 0.
    always_comb begin
        date_rst      = '0;
        date_rst.day  = DAY_W'(1);
        date_rst.mon  = MON_W'(1);
        date_rst.leap = (LEAP_PHASE == 2'b00);
    end

    // Successor date with month-length and year handling.
    always_comb begin
        last_day  = date_q.day >= month_days(date_q.mon, date_q.leap);
        last_mon  = date_q.mon >= MON_W'(MON_LIMIT);
        yr_inc    = date_q.yr + YR_W'(1);
        date_next = date_q;
        date_next.day = last_day ? DAY_W'(1) : date_q.day + DAY_W'(1);
        if (last_day) begin
            date_next.mon = last_mon ? MON_W'(1) : date_q.mon + MON_W'(1);
        end
        if (last_day && last_mon) begin
            date_next.yr   = yr_inc;
            date_next.leap = (yr_inc[1:0] == LEAP_PHASE);
        end
    end

    // Date register: load wins over the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_q <= date_rst;
        end else if (load) begin
            date_q <= load_val;
        end else if (advance) begin
            date_q <= date_next;
        end
    end

    // R8: without a carry or a commit the date holds.
    a_r8_hold_without_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(date_q));

    // R10: after a year step the leap flag matches the new offset.
    a_r10_leap_tracks_year: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && last_day && last_mon) |=>
            (date_q.leap == (date_q.yr[1:0] == LEAP_PHASE)) && (date_q.mon == MON_W'(1)));

    // R11: a committed date appears unchanged, whatever the carry did.
    a_r11_date_commit_exact: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (date_q == $past(load_val)));
endmodule

// File: rtl/cal_timekeeper.sv
// Top of the calendar timekeeper: host address decode, two commit slots
// (time and date), the time and date counters, and the read mux.
// Assumes sec_tick is a single-cycle pulse already synchronized to clk.
module cal_timekeeper
    import cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int TOD_BITS  = $bits(tod_t);
    localparam int DATE_BITS = $bits(date_t);

    logic  hit_time, hit_date;
    tod_t  wr_tod;
    date_t wr_date;
    logic  unused_wr_bits;

    logic                 tod_busy, tod_commit;
    logic [TOD_BITS-1:0]  tod_pend;
    logic                 date_busy, date_commit;
    logic [DATE_BITS-1:0] date_pend;

    tod_t  tod_now;
    date_t date_now;
    logic  day_carry;

    // Address decode of host writes.
    always_comb begin
        hit_time = wr_en && (wr_addr == ADDR_W'(OFS_TIME));
        hit_date = wr_en && (wr_addr == ADDR_W'(OFS_DATE));
    end

    // Field extraction from the written word.
    always_comb begin
        wr_tod.sec   = wr_data[SEC_LSB +: SEC_W];
        wr_tod.min   = wr_data[MIN_LSB +: MIN_W];
        wr_tod.hr    = wr_data[HR_LSB  +: HR_W];
        wr_date.day  = wr_data[DAY_LSB +: DAY_W];
        wr_date.mon  = wr_data[MON_LSB +: MON_W];
        wr_date.yr   = wr_data[YR_LSB  +: YR_W];
        wr_date.leap = wr_data[LEAP_POS];
    end

    // Bits of the write word that no field uses.
    always_comb unused_wr_bits = ^{wr_data[WORD_W-1:LEAP_POS+1], wr_data[15:14], wr_data[7:6]};

    cal_commit_slot #(.W(TOD_BITS)) u_tod_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (hit_time),
        .wr_val (wr_tod),
        .tick   (sec_tick),
        .busy_q (tod_busy),
        .commit (tod_commit),
        .pend_q (tod_pend)
    );

    cal_commit_slot #(.W(DATE_BITS)) u_date_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (hit_date),
        .wr_val (wr_date),
        .tick   (sec_tick),
        .busy_q (date_busy),
        .commit (date_commit),
        .pend_q (date_pend)
    );

    cal_tod_counter u_tod (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .load      (tod_commit),
        .load_val  (tod_t'(tod_pend)),
        .tod_q     (tod_now),
        .day_carry (day_carry)
    );

    cal_date_counter u_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (day_carry),
        .load     (date_commit),
        .load_val (date_t'(date_pend)),
        .date_q   (date_now)
    );

    // Read mux: packs the selected word into its field layout.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_CTRL)) begin
            rd_data[BUSY_TOD_POS]  = tod_busy;
            rd_data[BUSY_DATE_POS] = date_busy;
        end else if (rd_addr == ADDR_W'(OFS_TIME)) begin
            rd_data[SEC_LSB +: SEC_W] = tod_now.sec;
            rd_data[MIN_LSB +: MIN_W] = tod_now.min;
            rd_data[HR_LSB  +: HR_W]  = tod_now.hr;
        end else if (rd_addr == ADDR_W'(OFS_DATE)) begin
            rd_data[DAY_LSB +: DAY_W] = date_now.day;
            rd_data[MON_LSB +: MON_W] = date_now.mon;
            rd_data[YR_LSB  +: YR_W]  = date_now.yr;
            rd_data[LEAP_POS]         = date_now.leap;
        end
    end

    // R5: the time changes only on a seconds pulse.
    a_r5_time_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(tod_now));

    // R11: with a time commit on the same pulse, the date is never advanced.
    a_r11_no_carry_on_time_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_commit && !date_commit) |=> $stable(date_now));
endmodule

// File: tb/cal_timekeeper_test.sv
`timescale 1ns/1ps
module cal_timekeeper_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_DATE = 8'h10;
    localparam logic [7:0] A_TIME = 8'h14;

    cal_timekeeper #(.ADDR_W(AW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_tick(sec_tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Read a word; called right after a falling edge.
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic expect_word(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    // One write cycle, driven and released on falling edges.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One seconds pulse.
    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // Commit a time and date with one pulse, confirm, then step one second.
    task automatic set_and_step(input string tag, input logic [31:0] t, input logic [31:0] d,
                                input logic [31:0] exp_t, input logic [31:0] exp_d);
        wr(A_TIME, t);
        wr(A_DATE, d);
        tick();
        expect_word({tag, " commit time R5"}, A_TIME, t);
        expect_word({tag, " commit date R5"}, A_DATE, d);
        tick();
        expect_word({tag, " step time"}, A_TIME, exp_t);
        expect_word({tag, " step date"}, A_DATE, exp_d);
    endtask

    task automatic t_reset();
        expect_word("R1 ctrl after reset", A_CTRL, 32'h0);
        expect_word("R1 R2 time after reset", A_TIME, 32'h0);
        expect_word("R1 R3 date after reset", A_DATE, 32'h0000_0101);
        expect_word("R3 unmapped address", 8'h08, 32'h0);
    endtask

    task automatic t_commit_time();
        wr(A_TIME, 32'h000A_141E);
        expect_word("R4 time busy bit 8", A_CTRL, 32'h0000_0100);
        expect_word("R4 time held before commit", A_TIME, 32'h0);
        repeat (3) @(negedge clk);
        expect_word("R4 time held without tick", A_TIME, 32'h0);
        tick();
        expect_word("R5 time committed", A_TIME, 32'h000A_141E);
        expect_word("R5 busy cleared", A_CTRL, 32'h0);
        expect_word("R5 date untouched", A_DATE, 32'h0000_0101);
        tick();
        expect_word("R7 plain second step", A_TIME, 32'h000A_141F);
    endtask

    task automatic t_ignore_busy();
        wr(A_TIME, 32'h0001_0203);
        wr(A_TIME, 32'h0004_0506);
        wr(A_DATE, 32'h0005_0501);
        expect_word("R4 date busy bit 7", A_CTRL, 32'h0000_0180);
        wr(A_DATE, 32'h0007_0707);
        tick();
        expect_word("R6 first time kept", A_TIME, 32'h0001_0203);
        expect_word("R6 first date kept", A_DATE, 32'h0005_0501);
        expect_word("R5 both flags clear", A_CTRL, 32'h0);
    endtask

    task automatic t_date_only();
        wr(A_DATE, 32'h0005_021C);
        tick();
        expect_word("R11 date replaced", A_DATE, 32'h0005_021C);
        expect_word("R11 time still steps", A_TIME, 32'h0001_0204);
    endtask

    task automatic t_date_commit_drops_carry();
        wr(A_TIME, 32'h0017_3B3B);
        tick();
        wr(A_DATE, 32'h0003_0610);
        tick();
        expect_word("R11 carry discarded", A_DATE, 32'h0003_0610);
        expect_word("R11 R7 time wrapped", A_TIME, 32'h0);
    endtask

    task automatic t_rollovers();
        set_and_step("R7 hour carry", 32'h0000_3B3B, 32'h0005_041E, 32'h0001_0000, 32'h0005_041E);
        set_and_step("R7 no day carry", 32'h0017_3B3A, 32'h0005_041E, 32'h0017_3B3B, 32'h0005_041E);
        tick();
        expect_word("R8 midnight time", A_TIME, 32'h0);
        expect_word("R8 April 30 to May 1", A_DATE, 32'h0005_0501);
        set_and_step("R8 Jan 31", 32'h0017_3B3B, 32'h0005_011F, 32'h0, 32'h0005_0201);
        set_and_step("R8 Feb 28 plain year", 32'h0017_3B3B, 32'h0005_021C, 32'h0, 32'h0005_0301);
        set_and_step("R9 Feb 28 leap", 32'h0017_3B3B, 32'h0042_021C, 32'h0, 32'h0042_021D);
        set_and_step("R9 Feb 29 leap", 32'h0017_3B3B, 32'h0042_021D, 32'h0, 32'h0042_0301);
        set_and_step("R10 to leap year", 32'h0017_3B3B, 32'h0001_0C1F, 32'h0, 32'h0042_0101);
        set_and_step("R10 leaving leap year", 32'h0017_3B3B, 32'h0042_0C1F, 32'h0, 32'h0003_0101);
        set_and_step("R10 year offset wrap", 32'h0017_3B3B, 32'h003F_0C1F, 32'h0, 32'h0000_0101);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_commit_time();
        t_ignore_busy();
        t_date_only();
        t_date_commit_drops_carry();
        t_rollovers();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule